// File: doc/BRIEF.md
# Speculative Input Constraint Buffer

This block sits beside a speculative transaction engine. It records each memory word that the transaction reads while value tracking is enabled for that word. A load from a tracked address does not mark the line as read. It allocates an entry that holds the word address and the value seen at first read. While the transaction runs, branch resolution can narrow the set of values that the input may take. A branch on an expression `input + k` is turned into a bound on the raw input by subtracting `k` from the branch constant. A use of the value that cannot be tracked pins the input to the value it first had.

At commit, the transaction engine fetches the current value of every tracked word again and presents all of them at once on the check port. The block then reports, per entry, whether the fresh value still meets that entry's constraint. It also reports an overall verdict. A single failing entry means the transaction must abort. A clear pulse at commit or abort empties the buffer in one cycle.

Allocation never stalls. `alloc_ready` is held high, and a request that finds no free entry is refused through `alloc_overflow`, so the requester falls back to ordinary conflict tracking for that word. The check port has no back-pressure: every `check_valid` cycle produces exactly one result cycle.

Top module: `sym_input_guard`

## Requirements
- R1: After reset, or one cycle after `clear`, no entry is valid. A check in that state reports every `res_pass` bit as 1 and `res_ok` as 1. `clear` takes priority over every other request in the same cycle.
- R2: An allocate request whose address is not held, made while a free entry exists, writes the address and value into the lowest-numbered free entry. The entry is usable from the next cycle, and its constraint starts unrestricted.
- R3: An allocate request whose address is not held, made while all DEPTH entries are valid, raises `alloc_overflow` in the same cycle and changes no entry.
- R4: An allocate request whose address is already held raises `alloc_hit` in the same cycle and allocates nothing. The held entry keeps the value it recorded first.
- R5: A constraint request states that `(input + cons_offset) REL cons_const` holds, with both operands signed 32-bit. REL is coded on `cons_rel` as 0 = less-than, 1 = greater-or-equal, 2 = equal, 3 = not-equal. The block stores it as `input REL (cons_const - cons_offset)`, computed without wrap-around.
- R6: Each entry keeps one lower bound and one upper bound. A new less-than, greater-or-equal or equal constraint can only narrow the interval that is already held, never widen it.
- R7: A pin request constrains the input to equal the value recorded at allocation.
- R8: Each entry holds one not-equal exclusion. Repeating the same excluded value has no effect. A not-equal with a different value makes that entry fail every later check until it is cleared.
- R9: A check supplies the fresh value for entry i on `check_data[32*i +: 32]`. `res_valid` rises exactly one cycle after `check_valid`, together with `res_pass[i]` (1 when entry i is invalid or its constraint holds) and `res_ok`, which is the AND of all `res_pass` bits.
- R10: A constraint or pin request whose address is not held in the buffer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Invalidate all entries |
| alloc_valid | input | 1 | Allocate request on a tracked load |
| alloc_ready | output | 1 | Always 1; the allocate port never stalls |
| alloc_addr | input | ADDR_W | Word address of the load |
| alloc_data | input | 32 | Value loaded |
| alloc_hit | output | 1 | Request matched an existing entry |
| alloc_overflow | output | 1 | Request refused, buffer full |
| cons_valid | input | 1 | Constraint request from branch resolution |
| cons_addr | input | ADDR_W | Address of the constrained input |
| cons_rel | input | 2 | Relation code |
| cons_offset | input | 32 | Signed offset k of the tracked expression |
| cons_const | input | 32 | Signed branch constant |
| pin_valid | input | 1 | Pin-to-original request |
| pin_addr | input | ADDR_W | Address of the pinned input |
| check_valid | input | 1 | Commit-time check request |
| check_data | input | 32*DEPTH | Fresh values, entry i at bits 32*i |
| res_valid | output | 1 | Check result valid |
| res_pass | output | DEPTH | Per-entry pass flags |
| res_ok | output | 1 | All entries pass |

## Verification
The two allocation responses, `alloc_hit` and `alloc_overflow`, are combinational. The bench samples them one time unit after it drives the request, before the clock edge that commits the request. Allocations, constraints, pins and clears take effect at the clock edge that follows the request, so the bench always issues a check after that edge. Check results appear one register later. The bench drives `check_valid` at a falling edge and reads `res_*` at the next falling edge, one cycle later. Effects that cannot be seen directly, such as a refused allocation or a constraint on an absent address, are observed through later hit, overflow and check results.

// File: rtl/sig_pkg.sv
package sig_pkg;
  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_GE = 2'd1,
    REL_EQ = 2'd2,
    REL_NE = 2'd3
  } rel_e;

  localparam int VAL_W = 32;
  // two extra bits: constant minus offset, plus one for the exclusive upper bound
  localparam int BND_W = VAL_W + 2;
endpackage

// File: rtl/sig_lookup.sv
module sig_lookup #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DEPTH-1:0]              ent_valid,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
  input  logic [ADDR_W-1:0]             key,
  output logic [DEPTH-1:0]              match,
  output logic                          hit
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = ent_valid[i] && (ent_addr[i] == key);
  end
  assign hit = |match;

  // R4: an address is never held twice
  p_unique_addr_r4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));
endmodule

// File: rtl/sig_slot.sv
module sig_slot
  import sig_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    alloc_en,
  input  logic [ADDR_W-1:0]       alloc_addr,
  input  logic [VAL_W-1:0]        alloc_data,
  input  logic                    upd_cons,
  input  rel_e                    cons_rel,
  input  logic signed [BND_W-1:0] cons_bound,
  input  logic                    upd_pin,
  input  logic [VAL_W-1:0]        chk_data,
  output logic                    valid,
  output logic [ADDR_W-1:0]       addr,
  output logic                    pass
);
  localparam logic signed [BND_W-1:0] LO_OPEN = -(BND_W'(1) <<< (VAL_W-1));
  localparam logic signed [BND_W-1:0] HI_OPEN =  (BND_W'(1) <<< (VAL_W-1));

  logic [VAL_W-1:0]        orig_q;
  logic signed [BND_W-1:0] lo_q, hi_q, ne_q;
  logic                    ne_v_q, bad_q;

  logic signed [BND_W-1:0] lo_n, hi_n, ne_n, orig_s, chk_s;
  logic                    ne_v_n, bad_n;

  assign orig_s = BND_W'(signed'(orig_q));
  assign chk_s  = BND_W'(signed'(chk_data));

  always_comb begin
    lo_n   = lo_q;
    hi_n   = hi_q;
    ne_n   = ne_q;
    ne_v_n = ne_v_q;
    bad_n  = bad_q;
    if (upd_pin) begin
      if (orig_s > lo_n)      lo_n = orig_s;
      if (orig_s + 1 < hi_n)  hi_n = orig_s + 1;
    end
    if (upd_cons) begin
      unique case (cons_rel)
        REL_LT: if (cons_bound < hi_n) hi_n = cons_bound;
        REL_GE: if (cons_bound > lo_n) lo_n = cons_bound;
        REL_EQ: begin
          if (cons_bound > lo_n)     lo_n = cons_bound;
          if (cons_bound + 1 < hi_n) hi_n = cons_bound + 1;
        end
        REL_NE: begin
          if (ne_v_n && ne_n != cons_bound) bad_n = 1'b1;
          else begin
            ne_v_n = 1'b1;
            ne_n   = cons_bound;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      valid  <= 1'b0;
      addr   <= '0;
      orig_q <= '0;
      lo_q   <= LO_OPEN;
      hi_q   <= HI_OPEN;
      ne_q   <= '0;
      ne_v_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (alloc_en) begin
      valid  <= 1'b1;
      addr   <= alloc_addr;
      orig_q <= alloc_data;
      lo_q   <= LO_OPEN;
      hi_q   <= HI_OPEN;
      ne_q   <= '0;
      ne_v_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (valid) begin
      lo_q   <= lo_n;
      hi_q   <= hi_n;
      ne_q   <= ne_n;
      ne_v_q <= ne_v_n;
      bad_q  <= bad_n;
    end
  end

  assign pass = !valid ||
                ((chk_s >= lo_q) && (chk_s < hi_q) && !(ne_v_q && chk_s == ne_q) && !bad_q);

  // R6: bounds only narrow while an entry lives
  p_lo_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !alloc_en && !clr) |=> (lo_q >= $past(lo_q)));
  p_hi_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !alloc_en && !clr) |=> (hi_q <= $past(hi_q)));
  // R4: the recorded value never changes while valid
  p_orig_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !alloc_en && !clr) |=> (orig_q == $past(orig_q)));
endmodule

// File: rtl/sym_input_guard.sv
module sym_input_guard
  import sig_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   alloc_valid,
  output logic                   alloc_ready,
  input  logic [ADDR_W-1:0]      alloc_addr,
  input  logic [31:0]            alloc_data,
  output logic                   alloc_hit,
  output logic                   alloc_overflow,
  input  logic                   cons_valid,
  input  logic [ADDR_W-1:0]      cons_addr,
  input  logic [1:0]             cons_rel,
  input  logic [31:0]            cons_offset,
  input  logic [31:0]            cons_const,
  input  logic                   pin_valid,
  input  logic [ADDR_W-1:0]      pin_addr,
  input  logic                   check_valid,
  input  logic [32*DEPTH-1:0]    check_data,
  output logic                   res_valid,
  output logic [DEPTH-1:0]       res_pass,
  output logic                   res_ok
);
  logic [DEPTH-1:0]             ent_valid, ent_pass, a_match, c_match, p_match, free_oh, alloc_en;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic                         a_hit, c_hit, p_hit, full;
  logic signed [BND_W-1:0]      bound;

  assign alloc_ready = 1'b1;

  sig_lookup #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_look_alloc (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_addr(ent_addr),
    .key(alloc_addr), .match(a_match), .hit(a_hit));
  sig_lookup #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_look_cons (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_addr(ent_addr),
    .key(cons_addr), .match(c_match), .hit(c_hit));
  sig_lookup #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_look_pin (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_addr(ent_addr),
    .key(pin_addr), .match(p_match), .hit(p_hit));

  // lowest-numbered free entry
  always_comb begin
    free_oh = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_valid[i]) free_oh = DEPTH'(1) << i;
    end
  end

  assign full           = &ent_valid;
  assign alloc_hit      = alloc_valid && a_hit;
  assign alloc_overflow = alloc_valid && !a_hit && full;
  assign alloc_en       = (alloc_valid && !a_hit && !clear) ? free_oh : '0;

  // normalise "input + k REL c" to "input REL c - k"
  assign bound = BND_W'(signed'(cons_const)) - BND_W'(signed'(cons_offset));

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    sig_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clear),
      .alloc_en  (alloc_en[i]),
      .alloc_addr(alloc_addr),
      .alloc_data(alloc_data),
      .upd_cons  (cons_valid && c_hit && c_match[i]),
      .cons_rel  (rel_e'(cons_rel)),
      .cons_bound(bound),
      .upd_pin   (pin_valid && p_hit && p_match[i]),
      .chk_data  (check_data[32*i +: 32]),
      .valid     (ent_valid[i]),
      .addr      (ent_addr[i]),
      .pass      (ent_pass[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_pass  <= '1;
      res_ok    <= 1'b1;
    end else begin
      res_valid <= check_valid;
      if (check_valid) begin
        res_pass <= ent_pass;
        res_ok   <= &ent_pass;
      end
    end
  end

  p_clear_empties_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (ent_valid == '0));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_overflow && !clear) |=> $stable(ent_valid));
  p_hit_no_alloc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_hit && !clear) |=> $stable(ent_valid));
  p_res_due_r9: assert property (@(posedge clk) disable iff (!rst_n)
    check_valid |=> res_valid);
  p_res_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !check_valid |=> !res_valid);
  p_ok_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_ok == (res_pass == '1)));
endmodule

// File: tb/sym_input_guard_test.sv
`timescale 1ns/1ps
module sym_input_guard_test;
  localparam int DEPTH = 8;
  localparam int AW    = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 0, alloc_valid = 0, cons_valid = 0, pin_valid = 0, check_valid = 0;
  logic [AW-1:0] alloc_addr = '0, cons_addr = '0, pin_addr = '0;
  logic [31:0] alloc_data = '0, cons_offset = '0, cons_const = '0;
  logic [1:0] cons_rel = '0;
  logic [32*DEPTH-1:0] check_data = '0;
  logic alloc_ready, alloc_hit, alloc_overflow, res_valid, res_ok;
  logic [DEPTH-1:0] res_pass;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  sym_input_guard #(.DEPTH(DEPTH), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_addr(alloc_addr),
    .alloc_data(alloc_data), .alloc_hit(alloc_hit), .alloc_overflow(alloc_overflow),
    .cons_valid(cons_valid), .cons_addr(cons_addr), .cons_rel(cons_rel),
    .cons_offset(cons_offset), .cons_const(cons_const),
    .pin_valid(pin_valid), .pin_addr(pin_addr),
    .check_valid(check_valid), .check_data(check_data),
    .res_valid(res_valid), .res_pass(res_pass), .res_ok(res_ok));

  task automatic expect_eq(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_alloc(logic [AW-1:0] a, logic [31:0] d, logic exp_hit, logic exp_ovf, string req);
    @(negedge clk);
    alloc_valid = 1; alloc_addr = a; alloc_data = d;
    #1;
    expect_eq(req, {alloc_hit, alloc_overflow, alloc_ready}, {exp_hit, exp_ovf, 1'b1});
    @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic do_cons(logic [AW-1:0] a, logic [1:0] rel, int k, int c);
    @(negedge clk);
    cons_valid = 1; cons_addr = a; cons_rel = rel; cons_offset = k; cons_const = c;
    @(negedge clk);
    cons_valid = 0;
  endtask

  task automatic do_pin(logic [AW-1:0] a);
    @(negedge clk);
    pin_valid = 1; pin_addr = a;
    @(negedge clk);
    pin_valid = 0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1;
    @(negedge clk);
    clear = 0;
  endtask

  // check with value v in entry e, zero elsewhere; compare result one cycle later
  task automatic do_check(int e, logic [31:0] v, logic [DEPTH-1:0] exp_pass, string req);
    @(negedge clk);
    check_data = '0;
    check_data[32*e +: 32] = v;
    check_valid = 1;
    @(negedge clk);
    check_valid = 0;
    expect_eq(req, {res_valid, res_ok, res_pass}, {1'b1, (exp_pass == '1), exp_pass});
  endtask

  task automatic t_reset();
    expect_eq("R1 reset outputs", {alloc_hit, alloc_overflow, res_valid}, 3'b000);
    do_check(0, 32'd123, 8'hFF, "R1 empty check passes");
  endtask

  task automatic t_branch();
    do_alloc(32'h100, 32'd2, 0, 0, "R2 first alloc");
    do_cons(32'h100, 2'd0, 1, 8);              // (in+1) < 8  ->  in < 7
    do_check(0, 32'd4, 8'hFF, "R5 4 meets in<7");
    do_check(0, 32'd7, 8'hFE, "R5 7 breaks in<7");
    do_check(0, 32'd6, 8'hFF, "R5 6 meets in<7");
  endtask

  task automatic t_hit_pin();
    do_alloc(32'h100, 32'd9, 1, 0, "R4 hit");
    do_pin(32'h100);
    do_check(0, 32'd2, 8'hFF, "R7 pinned original 2 passes");
    do_check(0, 32'd9, 8'hFE, "R4 R7 later value 9 not kept");
    do_check(0, 32'd3, 8'hFE, "R7 3 breaks pin");
  endtask

  task automatic t_tighten();
    do_alloc(32'h200, 32'd10, 0, 0, "R2 second alloc");
    do_cons(32'h200, 2'd1, 0, 5);
    do_cons(32'h200, 2'd1, 0, 3);
    do_cons(32'h200, 2'd0, 0, 20);
    do_cons(32'h200, 2'd0, 0, 30);
    do_check(1, 32'd4,  8'hFC, "R6 4 below lower bound"); // entry0 sees 0, fails pin
    do_check(1, 32'd5,  8'hFE, "R6 5 at lower bound");
    do_check(1, 32'd19, 8'hFE, "R6 19 below upper bound");
    do_check(1, 32'd20, 8'hFC, "R6 20 at exclusive upper bound");
  endtask

  task automatic t_absent();
    do_cons(32'h999, 2'd0, 0, -100);
    do_pin(32'h998);
    do_check(1, 32'd6, 8'hFE, "R10 absent address has no effect");
    do_alloc(32'h999, 32'd1, 0, 0, "R10 absent address still a miss");
  endtask

  task automatic t_ne();
    do_cons(32'h200, 2'd3, 2, 14);             // in != 12
    do_check(1, 32'd12, 8'hFC, "R8 excluded 12 fails");
    do_check(1, 32'd13, 8'hFE, "R8 13 passes");
    do_cons(32'h200, 2'd3, 0, 12);
    do_check(1, 32'd13, 8'hFE, "R8 repeat exclusion no effect");
    do_cons(32'h200, 2'd3, 0, 15);
    do_check(1, 32'd13, 8'hFC, "R8 second exclusion poisons entry");
  endtask

  task automatic t_clear_edge();
    do_clear();
    do_check(1, 32'd13, 8'hFF, "R1 clear empties");
    do_alloc(32'h300, 32'd5, 0, 0, "R2 alloc after clear");
    do_cons(32'h300, 2'd2, 0, 32'h7FFFFFFF);
    do_check(0, 32'h7FFFFFFF, 8'hFF, "R5 R6 equal at max constant");
    do_check(0, 32'h7FFFFFFE, 8'hFE, "R2 entry0 reused, max-1 fails");
    do_cons(32'h300, 2'd2, -1, 0);             // in-1 == 0 -> in == 1, empties interval
    do_check(0, 32'h7FFFFFFF, 8'hFE, "R6 conflicting equal narrows to empty");
  endtask

  task automatic t_overflow();
    do_clear();
    for (int i = 0; i < DEPTH; i++) do_alloc(32'h10 + i, i, 0, 0, "R2 fill");
    do_alloc(32'h50, 32'd0, 0, 1, "R3 overflow when full");
    do_alloc(32'h50, 32'd0, 0, 1, "R3 refused address not stored");
    do_alloc(32'h13, 32'd0, 1, 0, "R4 hit when full");
    do_pin(32'h17);
    do_check(7, 32'd7, 8'hFF, "R2 lowest-first order puts 0x17 in entry 7");
    do_check(7, 32'd6, 8'h7F, "R7 entry 7 pinned to 7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_branch();
    t_hit_pin();
    t_tighten();
    t_absent();
    t_ne();
    t_clear_edge();
    t_overflow();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule